// File: doc/BRIEF.md
# Serial-Programmed Wiper Position Controller

This block is the digital half of a single-channel programmable resistor. A host writes a wiper code over a three-wire serial link: an active-low select, a serial clock and a data line. Bits shift into a serial register while the select is low. When the select goes high again, the word moves into a wiper register. That register is decoded into one-hot tap-switch enables that drive an external resistor ladder. Two further controls drive the ladder: an enable for the switch at the A end, and a control that shorts the wiper to the B end.

A build-time parameter chooses the ladder size. The fine setting has 256 positions and uses 8-bit words. The coarse setting has 33 positions and uses 6-bit words, and any code above 32 pins the wiper to the last tap.

The serial pins and the shutdown pin are asynchronous to the system clock, so each passes through a two-flop synchronizer first. The serial clock and the select each feed an edge detector after their synchronizer. The synchronous reset acts as the power-on event and loads the midscale code. An active-low shutdown input opens the A switch, releases every tap and shorts the wiper to B. During shutdown the wiper register and the serial port keep working, so a code written then takes effect when shutdown ends.

Top module: `dpot_core`

## Requirements
- R1: While the select is low, each rising edge of the serial clock shifts the data bit into the serial register. Words are sent MSB first, and the last bit sent becomes bit 0.
- R2: While the select is high, serial clock edges leave the serial register unchanged.
- R3: A rising edge of the select copies the serial register into the wiper register.
- R4: The word is 8 bits wide when FULL_RANGE=1 (256 taps) and 6 bits wide when FULL_RANGE=0 (33 taps).
- R5: Reset loads the midscale code into the wiper register: 0x80, which is tap 128, in the fine setting, and 0x10, which is tap 16, in the coarse setting.
- R6: tap_en bit i drives tap i. Code 0 selects tap 0 at the B end, and each step up in the code moves the wiper one tap toward A.
- R7: In the coarse setting, codes 0 to 32 select the tap with the same number, and codes 33 to 63 all select tap 32.
- R8: Outside shutdown, exactly one tap_en bit is high, a_sw_en is 1 and w2b_en is 0.
- R9: While shdn_n is low, all tap_en bits are 0, a_sw_en is 0 and w2b_en is 1.
- R10: During shutdown the wiper register keeps its value and still accepts serial writes. When shutdown ends, the taps show the latest code written.
- R11: If the select rises after a number of serial clocks other than the word width, the wiper register takes the last word-width bits shifted in.
- R12: Shifting alone does not change the wiper register; only a rising edge of the select does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-on preset) |
| ser_clk | input | 1 | Serial clock, sampled on its rising edge |
| ser_sel_n | input | 1 | Active-low select; its rising edge loads the word |
| ser_dat | input | 1 | Serial data, MSB first |
| shdn_n | input | 1 | Active-low shutdown |
| tap_en | output | NT (256 or 33) | One-hot tap switch enables, bit 0 at the B end |
| a_sw_en | output | 1 | A-terminal switch enable |
| w2b_en | output | 1 | Wiper-to-B short enable |

## Verification
The bench runs a fine and a coarse instance side by side on the same serial bus. Every write therefore also tests the coarse instance on only the low 6 bits. Codes above 32 exercise the coarse saturation; a design without clamping would drive no tap or a wrong tap. Over-long and short bursts check that the last bits shifted in are the ones kept. Serial clocks sent with the select high, and bursts checked before the select rises, catch a design that shifts while deselected or loads the register too early. A write made during shutdown must leave the outputs off and then appear once shutdown ends; a design that lost the register or froze the port in shutdown would show the old code or the reset code.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
  // Word width for the selected ladder size.
  function automatic int word_w(input bit full);
    return full ? 8 : 6;
  endfunction

  // Number of tap positions.
  function automatic int tap_n(input bit full);
    return full ? 256 : 33;
  endfunction

  // Midscale preset code.
  function automatic int mid_code(input bit full);
    return full ? 128 : 16;
  endfunction

  // Map a wiper code onto a tap index (coarse ladder clamps at its top tap).
  function automatic int code_to_pos(input int code, input bit full);
    if (!full && code > 32) return 32;
    return code;
  endfunction
endpackage

// File: rtl/dpot_sync.sv
module dpot_sync #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic q,
  output logic rise
);
  logic s1, s2, s3;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= RST_VAL;
      s2 <= RST_VAL;
      s3 <= RST_VAL;
    end else begin
      s1 <= din;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign q    = s2;
  assign rise = s2 & ~s3;
endmodule

// File: rtl/dpot_wiper_reg.sv
module dpot_wiper_reg #(
  parameter int WW    = 8,
  parameter int MID   = 128
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          shift_evt,
  input  logic          load_evt,
  input  logic          bit_in,
  output logic [WW-1:0] code
);
  localparam logic [WW-1:0] MID_V = MID[WW-1:0];

  logic [WW-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
      code  <= MID_V;
    end else begin
      if (shift_evt) shreg <= {shreg[WW-2:0], bit_in};
      if (load_evt)  code  <= shreg;
    end
  end

  a_r1_shift_in: assert property (@(posedge clk) disable iff (rst)
    shift_evt |=> shreg[0] == $past(bit_in));

  a_r2_shreg_idle: assert property (@(posedge clk) disable iff (rst)
    !shift_evt |=> $stable(shreg));

  a_r3_load_copy: assert property (@(posedge clk) disable iff (rst)
    load_evt |=> code == $past(shreg));

  a_r12_code_hold: assert property (@(posedge clk) disable iff (rst)
    !load_evt |=> $stable(code));

  a_r5_preset: assert property (@(posedge clk)
    rst |=> code == MID_V);
endmodule

// File: rtl/dpot_tap_decode.sv
module dpot_tap_decode #(
  parameter bit FULL = 1'b1,
  parameter int WW   = 8,
  parameter int NT   = 256
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [WW-1:0] code,
  input  logic          active,
  output logic [NT-1:0] tap_en,
  output logic          a_sw_en,
  output logic          w2b_en
);
  int pos;

  always_comb pos = dpot_pkg::code_to_pos(int'(code), FULL);

  for (genvar i = 0; i < NT; i++) begin : g_tap
    assign tap_en[i] = active && (pos == i);
  end

  assign a_sw_en = active;
  assign w2b_en  = ~active;

  a_r8_single_tap: assert property (@(posedge clk) disable iff (rst)
    active |-> ($countones(tap_en) == 1) && a_sw_en && !w2b_en);

  a_r9_shutdown_state: assert property (@(posedge clk) disable iff (rst)
    !active |-> (tap_en == '0) && w2b_en && !a_sw_en);

  if (!FULL) begin : g_clamp_chk
    a_r7_saturate: assert property (@(posedge clk) disable iff (rst)
      (active && int'(code) > NT - 1) |-> tap_en[NT-1]);
  end
endmodule

// File: rtl/dpot_core.sv
module dpot_core #(
  parameter bit FULL_RANGE = 1'b1,
  localparam int WW  = dpot_pkg::word_w(FULL_RANGE),
  localparam int NT  = dpot_pkg::tap_n(FULL_RANGE),
  localparam int MID = dpot_pkg::mid_code(FULL_RANGE)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ser_clk,
  input  logic          ser_sel_n,
  input  logic          ser_dat,
  input  logic          shdn_n,
  output logic [NT-1:0] tap_en,
  output logic          a_sw_en,
  output logic          w2b_en
);
  logic sclk_q, sclk_rise;
  logic sel_q, sel_rise;
  logic dat_q, dat_rise_unused;
  logic run_q, run_rise_unused;
  logic shift_evt, load_evt;
  logic [WW-1:0] code;

  dpot_sync #(.RST_VAL(1'b0)) u_sclk (.clk(clk), .rst(rst), .din(ser_clk),
    .q(sclk_q), .rise(sclk_rise));
  dpot_sync #(.RST_VAL(1'b1)) u_sel  (.clk(clk), .rst(rst), .din(ser_sel_n),
    .q(sel_q), .rise(sel_rise));
  dpot_sync #(.RST_VAL(1'b0)) u_dat  (.clk(clk), .rst(rst), .din(ser_dat),
    .q(dat_q), .rise(dat_rise_unused));
  dpot_sync #(.RST_VAL(1'b1)) u_run  (.clk(clk), .rst(rst), .din(shdn_n),
    .q(run_q), .rise(run_rise_unused));

  assign shift_evt = sclk_rise & ~sel_q;
  assign load_evt  = sel_rise;

  dpot_wiper_reg #(.WW(WW), .MID(MID)) u_wreg (
    .clk(clk), .rst(rst), .shift_evt(shift_evt), .load_evt(load_evt),
    .bit_in(dat_q), .code(code));

  dpot_tap_decode #(.FULL(FULL_RANGE), .WW(WW), .NT(NT)) u_dec (
    .clk(clk), .rst(rst), .code(code), .active(run_q),
    .tap_en(tap_en), .a_sw_en(a_sw_en), .w2b_en(w2b_en));

  a_r2_no_shift_deselected: assert property (@(posedge clk) disable iff (rst)
    sel_q |-> !shift_evt);

  a_r10_shutdown_keeps_port: assert property (@(posedge clk) disable iff (rst)
    (!run_q && load_evt) |=> (code == $past(u_wreg.shreg)));

  // Unused edge outputs of level-only synchronizers.
  logic unused_ok;
  assign unused_ok = dat_rise_unused ^ run_rise_unused ^ sclk_q;
endmodule

// File: tb/dpot_core_test.sv
module dpot_core_test;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b0, ser_sel_n = 1'b1, ser_dat = 1'b0, shdn_n = 1'b1;
  logic [255:0] tap_f;
  logic [32:0]  tap_c;
  logic a_f, w_f, a_c, w_c;

  int checks = 0;
  int errors = 0;
  int sh_f = 0;   // bench model of the serial registers
  int sh_c = 0;

  always #(CLK_P/2) clk = ~clk;

  dpot_core #(.FULL_RANGE(1'b1)) uut (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_sel_n(ser_sel_n),
    .ser_dat(ser_dat), .shdn_n(shdn_n), .tap_en(tap_f), .a_sw_en(a_f), .w2b_en(w_f));

  dpot_core #(.FULL_RANGE(1'b0)) uut33 (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_sel_n(ser_sel_n),
    .ser_dat(ser_dat), .shdn_n(shdn_n), .tap_en(tap_c), .a_sw_en(a_c), .w2b_en(w_c));

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int clamp33(input int c);
    return (c > 32) ? 32 : c;
  endfunction

  task automatic chk_f(input string req, input int idx);
    logic [255:0] e;
    e = 256'b1 << idx;
    checks++;
    if (tap_f !== e || a_f !== 1'b1 || w_f !== 1'b0) begin
      errors++;
      $display("FAIL %s fine: tap=%h a=%b w=%b expected tap %0d a=1 w=0", req, tap_f, a_f, w_f, idx);
    end
  endtask

  task automatic chk_c(input string req, input int idx);
    logic [32:0] e;
    e = 33'b1 << idx;
    checks++;
    if (tap_c !== e || a_c !== 1'b1 || w_c !== 1'b0) begin
      errors++;
      $display("FAIL %s coarse: tap=%h a=%b w=%b expected tap %0d a=1 w=0", req, tap_c, a_c, w_c, idx);
    end
  endtask

  task automatic chk_off(input string req);
    checks++;
    if (tap_f !== '0 || tap_c !== '0 || a_f !== 1'b0 || a_c !== 1'b0 || w_f !== 1'b1 || w_c !== 1'b1) begin
      errors++;
      $display("FAIL %s shutdown: tapf=%h tapc=%h a=%b%b w=%b%b expected all taps 0 a=0 w=1",
               req, tap_f, tap_c, a_f, a_c, w_f, w_c);
    end
  endtask

  // Shift n bits of val, MSB first; select must already be low.
  task automatic shift_bits(input logic [31:0] val, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      ser_dat = val[i];
      idle(4);
      ser_clk = 1'b1;
      idle(4);
      ser_clk = 1'b0;
      idle(4);
      sh_f = ((sh_f << 1) | int'(val[i])) & 8'hFF;
      sh_c = ((sh_c << 1) | int'(val[i])) & 6'h3F;
    end
  endtask

  task automatic write_word(input logic [31:0] val, input int n);
    ser_sel_n = 1'b0;
    idle(4);
    shift_bits(val, n);
    ser_sel_n = 1'b1;
    idle(8);
  endtask

  task automatic t_reset;
    chk_f("R5", 128);
    chk_c("R5", 16);
  endtask

  task automatic t_codes;
    write_word(32'h00, 8);  chk_f("R6", 0);   chk_c("R6", 0);
    write_word(32'h01, 8);  chk_f("R1", 1);   chk_c("R1", 1);
    write_word(32'h80, 8);  chk_f("R4", 128); chk_c("R4", 0);
    write_word(32'hA5, 8);  chk_f("R3", 165); chk_c("R7", clamp33(8'hA5 & 8'h3F));
    write_word(32'h20, 8);  chk_c("R7", 32);
    write_word(32'h21, 8);  chk_c("R7", 32);
    write_word(32'h3F, 8);  chk_c("R7", 32);
    write_word(32'h1F, 8);  chk_f("R6", 31);  chk_c("R8", 31);
  endtask

  task automatic t_deselected_clocks;
    write_word(32'h5A, 8);
    ser_dat = 1'b1;
    for (int i = 0; i < 8; i++) begin
      ser_clk = 1'b1; idle(4); ser_clk = 1'b0; idle(4);
    end
    chk_f("R2", 8'h5A);
    // Empty select pulse reloads the untouched serial register.
    ser_sel_n = 1'b0; idle(6); ser_sel_n = 1'b1; idle(8);
    chk_f("R2", 8'h5A);
    chk_c("R2", 8'h1A);
  endtask

  task automatic t_no_early_load;
    ser_sel_n = 1'b0;
    idle(4);
    shift_bits(32'hFF, 8);
    chk_f("R12", 8'h5A);
    chk_c("R12", 8'h1A);
    ser_sel_n = 1'b1;
    idle(8);
    chk_f("R3", 255);
    chk_c("R7", 32);
  endtask

  task automatic t_odd_lengths;
    write_word(32'hABC, 12);
    chk_f("R11", 8'hBC);
    chk_c("R11", clamp33(6'h3C));
    write_word(32'h5, 3);
    chk_f("R11", sh_f);
    chk_c("R11", clamp33(sh_c));
    write_word(32'h0, 2);
    chk_f("R11", sh_f);
    chk_c("R11", clamp33(sh_c));
  endtask

  task automatic t_shutdown;
    write_word(32'h40, 8);
    shdn_n = 1'b0;
    idle(6);
    chk_off("R9");
    write_word(32'h07, 8);
    chk_off("R10");
    shdn_n = 1'b1;
    idle(6);
    chk_f("R10", 7);
    chk_c("R10", 7);
  endtask

  initial begin
    #(CLK_P * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog (R1..R12 run) actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(5);
    rst = 1'b0;
    idle(6);
    t_reset();
    t_codes();
    t_deselected_clocks();
    t_no_early_load();
    t_odd_lengths();
    t_shutdown();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule